// File: doc/BRIEF.md
# Temperature-Scaled Self-Discharge Counter

This block keeps the self-discharge tally of a battery monitor. A slow base tick, arriving sixteen times per hour, is divided by a ratio that the current 3-bit temperature step selects. Each completed division window adds one to a 16-bit count. The ratios are 128, 64, 32, 16, 8, 4, 2 and 1 for step codes 0 to 7. The count therefore advances at one eighth of its nominal rate of one per hour in the coldest band. It reaches sixteen times that rate in the hottest band. The nominal rate belongs to code 3, the 20 to 30 degree band.

The count only advances while the monitor is in its normal operating state (`run_en` high). It freezes while the monitor sleeps. A host maintains the count through a combined temperature/clear register. The upper three bits show the present step code. Writing a one to bit 2 requests a clear, and bit 2 drops back to zero by itself once the count has been zeroed. A controller with three named states sequences this: SLEEP, COUNT and CLEAR. Its transitions are SLEEP to COUNT on `run_en` high, COUNT to SLEEP on `run_en` low, SLEEP or COUNT to CLEAR on a pending clear request, and CLEAR to COUNT or SLEEP according to `run_en`.

Top module: `sdc_selfdis_counter`

## Requirements
- R1: After reset `sd_count` is 0000h and `tc_reg` is 00h.
- R2: With step code 3 and `run_en` high, every 16th base tick adds one to `sd_count`, and ticks 1 to 15 of a window leave it unchanged.
- R3: Step code k needs 2^(7-k) base ticks per count: 128 ticks for code 0 and 1 tick for code 7.
- R4: `tc_reg[7:5]` holds `temp_step` as sampled one clock earlier. Bits 4, 3, 1 and 0 always read 0.
- R5: While `run_en` is low, base ticks change neither `sd_count` nor the progress of the current division window. When `run_en` returns high, counting resumes from where it stopped.
- R6: `sd_count` wraps from FFFFh to 0000h on the next completed window, with no flag raised.
- R7: A write with `tc_wr_data[2]` = 1 sets `tc_reg[2]`. Two clocks later `sd_count` is 0000h, `tc_reg[2]` is back to 0, and the division window restarts from zero. A clear also works while `run_en` is low.
- R8: A write with `tc_wr_data[2]` = 0 changes neither `sd_count` nor `tc_reg`, whatever the other data bits are.
- R9: A step code change in the middle of a division window takes effect only at the next window boundary. The window in progress completes at its old ratio, and no tick is lost or counted twice.
- R10: `sd_count` changes only by +1 or to 0000h. It is updated on the clock edge that samples the tick completing a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle pulse, sixteen per hour |
| run_en | input | 1 | High in normal operating state, low in sleep |
| temp_step | input | 3 | Temperature step code, 0 = coldest, 7 = hottest |
| tc_wr_en | input | 1 | Write strobe for the temperature/clear register |
| tc_wr_data | input | 8 | Write data; only bit 2 (clear request) has effect |
| sd_count | output | 16 | Self-discharge count |
| tc_reg | output | 8 | Temperature/clear register read value |

## Verification
The divider is tried with single ticks at the nominal code, where the first fifteen ticks of a window must show no change and the sixteenth one count. It is then tried at the extreme codes 0 and 7, which separate a correct ratio table from one that is reversed or off by a factor of two. A code change in the middle of a window separates boundary-aligned reloading from immediate switching, because an immediate switch would produce counts several ticks early. Ticks while asleep, a long burst at code 7 across FFFFh, and clear writes with and without bit 2 distinguish real gating, wrap and clear behaviour from counters that run on, saturate, or react to any write.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [1:0] {
        S_SLEEP = 2'd0,
        S_COUNT = 2'd1,
        S_CLEAR = 2'd2
    } sdc_state_t;
endpackage

// File: rtl/sdc_prescaler.sv
module sdc_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              restart,
    input  logic [CODE_W-1:0] code_in,
    output logic              step,
    output logic [(1<<CODE_W)-2:0] pre_q
);
    localparam int MAXC  = (1 << CODE_W) - 1;
    localparam int PRE_W = MAXC;

    logic [CODE_W-1:0] act_code;
    logic [PRE_W:0]    limit;
    logic              last;

    always_comb begin
        limit = (PRE_W+1)'(1) << (MAXC - int'(act_code));
        last  = ({1'b0, pre_q} == (limit - (PRE_W+1)'(1)));
        step  = tick_en && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q    <= '0;
            act_code <= CODE_W'(MAXC / 2);
        end else if (restart) begin
            pre_q    <= '0;
            act_code <= code_in;
        end else if (tick_en) begin
            if (last) begin
                pre_q    <= '0;
                act_code <= code_in;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end else if (pre_q == '0) begin
            act_code <= code_in;
        end
    end
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic                  clr_req,
    output logic                  clr_pend,
    output logic                  cnt_en,
    output logic                  clr_do,
    output sdc_pkg::sdc_state_t   state
);
    import sdc_pkg::*;

    sdc_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_SLEEP: begin
                if (clr_pend)    nxt = S_CLEAR;
                else if (run_en) nxt = S_COUNT;
            end
            S_COUNT: begin
                if (clr_pend)     nxt = S_CLEAR;
                else if (!run_en) nxt = S_SLEEP;
            end
            S_CLEAR: begin
                nxt = run_en ? S_COUNT : S_SLEEP;
            end
            default: nxt = S_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_SLEEP;
        else        state <= nxt;
    end

    always_comb begin
        cnt_en = (state == S_COUNT);
        clr_do = (state == S_CLEAR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       clr_pend <= 1'b0;
        else if (clr_req) clr_pend <= 1'b1;
        else if (clr_do)  clr_pend <= 1'b0;
    end
endmodule

// File: rtl/sdc_accum.sv
module sdc_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             zero,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (zero) count <= '0;
        else if (inc)  count <= count + 1'b1;
    end
endmodule

// File: rtl/sdc_selfdis_counter.sv
module sdc_selfdis_counter #(
    parameter int CNT_W   = 16,
    parameter int CODE_W  = 3,
    parameter int REG_W   = 8,
    parameter int CLR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              run_en,
    input  logic [CODE_W-1:0] temp_step,
    input  logic              tc_wr_en,
    input  logic [REG_W-1:0]  tc_wr_data,
    output logic [CNT_W-1:0]  sd_count,
    output logic [REG_W-1:0]  tc_reg
);
    import sdc_pkg::*;

    localparam int PRE_W = (1 << CODE_W) - 1;
    localparam int LOW_W = REG_W - CODE_W;

    logic              clr_req, clr_pend, cnt_en, clr_do, step;
    logic [PRE_W-1:0]  pre_cnt;
    logic [CODE_W-1:0] temp_q;
    sdc_state_t        fsm_state;

    assign clr_req = tc_wr_en && tc_wr_data[CLR_BIT];

    sdc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .clr_req  (clr_req),
        .clr_pend (clr_pend),
        .cnt_en   (cnt_en),
        .clr_do   (clr_do),
        .state    (fsm_state)
    );

    sdc_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (cnt_en && base_tick),
        .restart (clr_do),
        .code_in (temp_step),
        .step    (step),
        .pre_q   (pre_cnt)
    );

    sdc_accum #(.CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (step),
        .zero  (clr_do),
        .count (sd_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) temp_q <= '0;
        else        temp_q <= temp_step;
    end

    always_comb begin
        logic [LOW_W-1:0] low;
        low          = '0;
        low[CLR_BIT] = clr_pend;
        tc_reg       = {temp_q, low};
    end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
    parameter int CNT_W   = 16,
    parameter int CODE_W  = 3,
    parameter int REG_W   = 8,
    parameter int CLR_BIT = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 base_tick,
    input logic [CODE_W-1:0]    temp_step,
    input logic                 tc_wr_en,
    input logic [CNT_W-1:0]     sd_count,
    input logic [REG_W-1:0]     tc_reg,
    input sdc_pkg::sdc_state_t  fsm_state
);
    import sdc_pkg::*;

    // R10
    assert_step_or_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_count) |-> (sd_count == $past(sd_count) + 1'b1) || (sd_count == '0));

    // R5
    assert_sleep_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_SLEEP) |=> $stable(sd_count));

    // R7
    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_CLEAR) |=> (sd_count == '0));

    // R7
    assert_clear_selfreset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_CLEAR && !tc_wr_en) |=> !tc_reg[CLR_BIT]);

    // R2
    assert_no_tick_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_tick && fsm_state != S_CLEAR) |=> $stable(sd_count));

    // R4
    assert_temp_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tc_reg[REG_W-1 -: CODE_W] == $past(temp_step)));
endmodule

bind sdc_selfdis_counter sdc_checker #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .REG_W(REG_W), .CLR_BIT(CLR_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .temp_step (temp_step),
    .tc_wr_en  (tc_wr_en),
    .sd_count  (sd_count),
    .tc_reg    (tc_reg),
    .fsm_state (fsm_state)
);

// File: tb/test_sdc_selfdis_counter.sv
module test_sdc_selfdis_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic        run_en = 1'b0;
    logic [2:0]  temp_step = 3'd3;
    logic        tc_wr_en = 1'b0;
    logic [7:0]  tc_wr_data = 8'h00;
    logic [15:0] sd_count;
    logic [7:0]  tc_reg;

    always #5 clk = ~clk;

    sdc_selfdis_counter i_sdc_selfdis_counter (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .run_en(run_en),
        .temp_step(temp_step), .tc_wr_en(tc_wr_en), .tc_wr_data(tc_wr_data),
        .sd_count(sd_count), .tc_reg(tc_reg)
    );

    typedef struct {
        string       req;
        logic [15:0] cnt;
        logic [7:0]  rg;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    int          m_pre = 0;
    int          m_act = 3;
    logic [2:0]  m_temp = 3'd3;
    logic [15:0] m_cnt = 16'h0;
    bit          m_pend = 0;

    function automatic logic [7:0] m_reg();
        return {m_temp, 2'b00, m_pend, 2'b00};
    endfunction

    task automatic push(input string req);
        exp_t e;
        e.req = req; e.cnt = m_cnt; e.rg = m_reg();
        q.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (sd_count !== e.cnt || tc_reg !== e.rg) begin
                n_bad++;
                $display("FAIL %s: count=%h reg=%h expected count=%h reg=%h",
                         e.req, sd_count, tc_reg, e.cnt, e.rg);
            end
        end
    end

    function automatic void model_tick();
        int lim;
        lim = 1 << (7 - m_act);
        if (m_pre == lim - 1) begin
            m_pre = 0; m_cnt = m_cnt + 16'd1; m_act = int'(m_temp);
        end else begin
            m_pre++;
        end
    endfunction

    task automatic burst(input int n, input string req, input bit each);
        @(negedge clk); base_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (run_en) model_tick();
            #1;
            if (each) push(req);
        end
        base_tick = 1'b0;
        if (!each) push(req);
    endtask

    task automatic tick1(input string req);
        burst(1, req, 1'b1);
        @(negedge clk);
    endtask

    task automatic set_temp(input logic [2:0] t, input string req);
        @(negedge clk); temp_step = t;
        @(posedge clk); #1;
        m_temp = t;
        if (m_pre == 0) m_act = int'(t);
        push(req);
    endtask

    task automatic set_run(input logic r);
        @(negedge clk); run_en = r;
        repeat (2) @(posedge clk);
    endtask

    task automatic write_tc(input logic [7:0] d, input string req);
        @(negedge clk); tc_wr_en = 1'b1; tc_wr_data = d;
        @(posedge clk); #1; tc_wr_en = 1'b0;
        if (d[2]) begin
            m_pend = 1; push(req);
            repeat (3) @(posedge clk); #1;
            m_pend = 0; m_cnt = 16'h0; m_pre = 0; m_act = int'(m_temp);
        end
        push(req);
    endtask

    initial begin
        #(1_800_000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; m_temp = 3'd0;
        // R1: reset state (temp field shows 0 before first sampling)
        if (sd_count !== 16'h0 || tc_reg !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: count=%h reg=%h expected count=0000 reg=00", sd_count, tc_reg);
        end
        n_cmp++;
        rst_n = 1'b1;
        set_temp(3'd3, "R4 code 3 field");
        set_run(1'b1);
        // R2: 15 ticks no count, 16th counts
        for (int i = 0; i < 16; i++) tick1("R2 nominal window");
        // R3: code 7, one tick per count
        set_temp(3'd7, "R4 code 7 field");
        for (int i = 0; i < 3; i++) tick1("R3 code 7");
        // R3: code 0, 128 ticks per count
        set_temp(3'd0, "R4 code 0 field");
        burst(127, "R3 code 0 before boundary", 1'b0);
        burst(1, "R3 code 0 at boundary", 1'b0);
        // R9: mid-window change
        set_temp(3'd3, "R4 code 3 field");
        burst(5, "R9 partial", 1'b0);
        set_temp(3'd7, "R9 change held back");
        burst(10, "R9 old ratio still", 1'b0);
        tick1("R9 window completes at old ratio");
        tick1("R9 new ratio now");
        // R5: sleep gating
        set_temp(3'd3, "R4 code 3 field");
        burst(7, "R5 before sleep", 1'b0);
        set_run(1'b0);
        burst(40, "R5 ticks while asleep", 1'b0);
        set_run(1'b1);
        burst(8, "R5 resume window", 1'b0);
        tick1("R5 resumed count");
        // R8: write without clear bit
        write_tc(8'hFB, "R8 no clear");
        // R7: clear
        write_tc(8'h04, "R7 clear");
        set_run(1'b0);
        set_temp(3'd7, "R4 code 7 field");
        set_run(1'b1);
        tick1("R7 after clear");
        set_run(1'b0);
        write_tc(8'h04, "R7 clear while asleep");
        set_run(1'b1);
        // R6: wrap
        burst(65535, "R6 at FFFF", 1'b0);
        tick1("R6 wrap to 0000");
        tick1("R10 count after wrap");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule